// File: doc/BRIEF.md
# Serial Flash Main-Array Read Sequencer

This block is the read side of a serial flash slave. It samples chip select, serial clock and serial data in the system clock domain. An 8-bit command and a 24-bit address arrive MSB first on SCK rising edges. The block then skips the number of filler bytes that the command calls for. After that it returns array bytes MSB first, one bit on each SCK falling edge, for as long as chip select stays low.

The address is split into a page number and a byte offset. The split depends on a page-size select: 264 or 256 bytes per page. While data streams out, the offset and page counters advance by one of two rules. A streaming read moves on to the next page and, after the last page, returns to page 0. A single-page read returns to the start of the same page. The array is a small computed pattern, so that every wrap case can be reached in a short run.

Top module: `frd_reader`

## Requirements
- R1: While cs_n is low, si is sampled on each SCK rising edge, MSB first. The first 8 bits form the command and the next 24 bits form the address.
- R2: With page264=1 the page is address bits [20:9] and the offset is bits [8:0]. With page264=0 the page is bits [19:8] and the offset is bits [7:0]. The page is reduced modulo NUM_PAGES by keeping its low bits.
- R3: With page264=1, a starting offset of 264 or more is reduced by 264.
- R4: Filler bytes after the address: command 8'h03 takes none, 8'h0B takes one, and 8'hE8 and 8'hD2 take four each.
- R5: The first data bit (bit 7 of the start byte) appears on the SCK falling edge after the last header rising edge. Each later falling edge gives the next bit, MSB first. This holds with SCK idling low or high.
- R6: For 8'h03, 8'h0B and 8'hE8, the byte after the last offset of a page is offset 0 of the next page. The last offset is 263 with page264=1 and 255 otherwise.
- R7: For those same streaming commands, the byte after the last offset of page NUM_PAGES-1 is page 0, offset 0.
- R8: For 8'hD2, the byte after the last offset of the page is offset 0 of the same page.
- R9: so_en falls within one clock of cs_n going high. The next low period of cs_n starts a fresh command.
- R10: Any other command value leaves so_en low until cs_n goes high.
- R11: The byte at page p and offset o is (o mod 256 + 165*(o div 256) + 71*p) mod 256.
- R12: After reset, so_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sck | input | 1 | Serial clock, sampled by clk |
| si | input | 1 | Serial data in |
| page264 | input | 1 | 1: 264-byte pages, 0: 256-byte pages; taken when the address is complete |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for so; low means high impedance |

## Verification
The stream is started just below a page end under each streaming command and each page size, so a wrong last-offset value or a missing page step shows up. Starts on the last page show whether the counter returns to page 0. Single-page starts in both sizes show whether the counter stays on the page instead of moving on. An out-of-range offset and page, an unknown command and a mid-byte deselect check address reduction, silence and restart. SCK idling both low and high checks the first-bit timing, and this also separates the three filler-byte counts.

// File: rtl/frd_pkg.sv
// Shared definitions for the array read sequencer.
// Assumes the command set is fixed: three streaming reads and one page read.
package frd_pkg;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_HDR  = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    localparam logic [7:0] OP_RD_SLOW = 8'h03;
    localparam logic [7:0] OP_RD_FAST = 8'h0B;
    localparam logic [7:0] OP_RD_LEG  = 8'hE8;
    localparam logic [7:0] OP_RD_PAGE = 8'hD2;

    // Filler byte count for a recognised command
    function automatic logic [2:0] filler_bytes(input logic [7:0] op);
        case (op)
            OP_RD_FAST: filler_bytes = 3'd1;
            OP_RD_LEG,
            OP_RD_PAGE: filler_bytes = 3'd4;
            default:    filler_bytes = 3'd0;
        endcase
    endfunction

    // True for any read command this block serves
    function automatic logic cmd_known(input logic [7:0] op);
        cmd_known = (op == OP_RD_SLOW) || (op == OP_RD_FAST) ||
                    (op == OP_RD_LEG)  || (op == OP_RD_PAGE);
    endfunction

    // True when the read carries on into the next page
    function automatic logic cmd_streams(input logic [7:0] op);
        cmd_streams = (op != OP_RD_PAGE);
    endfunction

endpackage

// File: rtl/frd_edge.sv
// SCK edge detector in the clk domain.
// Assumes sck and cs_n are already synchronous to clk and that each SCK
// level lasts at least two clk cycles.
module frd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall
);
    logic sck_q;

    // Hold the previous SCK level
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign sck_rise = !cs_n &&  sck && !sck_q;
    assign sck_fall = !cs_n && !sck &&  sck_q;
endmodule

// File: rtl/frd_addr.sv
// Page and offset counters for the array read.
// Loads a start address in the selected page size, reduces it into range,
// then steps one byte per advance pulse with the streaming or same-page wrap.
// Assumes NUM_PAGES is a power of two, at least 2.
module frd_addr #(
    parameter int NUM_PAGES = 4,
    localparam int PG_W = $clog2(NUM_PAGES),
    localparam int AW   = PG_W + 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   addr,
    input  logic            p264_in,
    input  logic            adv,
    input  logic            streams,
    output logic [PG_W-1:0] page,
    output logic [8:0]      off
);
    localparam logic [PG_W-1:0] LAST_PG = PG_W'(NUM_PAGES - 1);

    logic       mode264;
    logic [8:0] last_off;
    logic [8:0] raw_off;

    assign last_off = mode264 ? 9'd263 : 9'd255;
    assign raw_off  = addr[8:0];

    // Load the start address or step to the next byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode264 <= 1'b0;
            page    <= '0;
            off     <= '0;
        end else if (load) begin
            mode264 <= p264_in;
            if (p264_in) begin
                page <= addr[PG_W+8:9];
                off  <= (raw_off >= 9'd264) ? raw_off - 9'd264 : raw_off;
            end else begin
                page <= addr[PG_W+7:8];
                off  <= {1'b0, addr[7:0]};
            end
        end else if (adv) begin
            if (off == last_off) begin
                off <= '0;
                if (streams) page <= (page == LAST_PG) ? '0 : page + 1'b1;
            end else begin
                off <= off + 9'd1;
            end
        end
    end

    a_r3_off_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        off <= last_off);
    a_r6_next_page: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && off == last_off && streams && page != LAST_PG)
        |=> (page == PG_W'($past(page) + 1'b1)) && (off == 9'd0));
    a_r7_array_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && off == last_off && streams && page == LAST_PG)
        |=> (page == '0) && (off == 9'd0));
    a_r8_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && off == last_off && !streams)
        |=> (page == $past(page)) && (off == 9'd0));
endmodule

// File: rtl/frd_array.sv
// Behavioural read-only array: a computed byte per page and offset.
// Assumes the offset is already in range for the page size.
module frd_array #(
    parameter int NUM_PAGES = 4,
    localparam int PG_W = $clog2(NUM_PAGES)
) (
    input  logic [PG_W-1:0] page,
    input  logic [8:0]      off,
    output logic [7:0]      rd_byte
);
    logic [7:0] pg_term;

    // Page contribution to the pattern
    always_comb pg_term = 8'(32'(page) * 71);

    // Byte value from offset and page
    always_comb rd_byte = off[7:0] + (off[8] ? 8'hA5 : 8'h00) + pg_term;
endmodule

// File: rtl/frd_reader.sv
// Main-array read sequencer of a serial flash slave.
// Takes command, address and filler bits on SCK rising edges and returns
// array data on SCK falling edges while cs_n is low. Deselect ends the read.
// Assumes all inputs are synchronous to clk and SCK is much slower than clk.
module frd_reader #(
    parameter int NUM_PAGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic page264,
    output logic so,
    output logic so_en
);
    import frd_pkg::*;

    localparam int PG_W = $clog2(NUM_PAGES);
    localparam int AW   = PG_W + 9;

    phase_e          phase;
    logic [5:0]      cnt;
    logic [5:0]      hdr_len;
    logic [6:0]      cmd_sh;
    logic [7:0]      cmd_now;
    logic [AW-1:0]   addr_sh;
    logic [AW-1:0]   addr_now;
    logic            streams_q;
    logic [2:0]      bidx;
    logic            so_q;
    logic            sck_rise;
    logic            sck_fall;
    logic            load;
    logic            adv;
    logic [PG_W-1:0] page;
    logic [8:0]      off;
    logic [7:0]      rd_byte;

    frd_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    // Command and address as they stand with the current bit included
    assign cmd_now  = {cmd_sh, si};
    assign addr_now = (cnt < 6'd24) ? {addr_sh[AW-2:0], si} : addr_sh;
    assign load     = sck_rise && (phase == PH_HDR) && (cnt == hdr_len - 6'd1);
    assign adv      = sck_fall && (phase == PH_DATA) && (bidx == 3'd7);

    // Header sequencing and serial output
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            phase <= PH_CMD;
            cnt   <= '0;
            so_en <= 1'b0;
            bidx  <= '0;
            if (!rst_n) begin
                cmd_sh    <= '0;
                addr_sh   <= '0;
                hdr_len   <= 6'd24;
                streams_q <= 1'b0;
                so_q      <= 1'b0;
            end
        end else if (sck_rise) begin
            case (phase)
                PH_CMD: begin
                    cmd_sh <= cmd_now[6:0];
                    cnt    <= cnt + 6'd1;
                    if (cnt == 6'd7) begin
                        cnt       <= '0;
                        hdr_len   <= 6'd24 + {filler_bytes(cmd_now), 3'b000};
                        streams_q <= cmd_streams(cmd_now);
                        phase     <= cmd_known(cmd_now) ? PH_HDR : PH_SKIP;
                    end
                end
                PH_HDR: begin
                    addr_sh <= addr_now;
                    cnt     <= cnt + 6'd1;
                    if (load) phase <= PH_DATA;
                end
                default: ;
            endcase
        end else if (sck_fall && phase == PH_DATA) begin
            so_q  <= rd_byte[3'd7 - bidx];
            so_en <= 1'b1;
            bidx  <= bidx + 3'd1;
        end
    end

    frd_addr #(.NUM_PAGES(NUM_PAGES)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr    (addr_now),
        .p264_in (page264),
        .adv     (adv),
        .streams (streams_q),
        .page    (page),
        .off     (off)
    );

    frd_array #(.NUM_PAGES(NUM_PAGES)) u_array (
        .page    (page),
        .off     (off),
        .rd_byte (rd_byte)
    );

    assign so = so_q;

    a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_en);
    a_r5_bits_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so_q));
    a_r5_enable_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_en) |-> $past(sck_fall));
    a_r10_unknown_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> !so_en);
endmodule

// File: tb/tb_frd_reader.sv
module tb_frd_reader;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic page264 = 1'b0;
    logic so;
    logic so_en;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    mon_on = 1'b0;
    logic  exp_en = 1'b0;
    logic  exp_so = 1'b0;
    string cur_req = "R12";

    frd_reader #(.NUM_PAGES(NP)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .page264(page264), .so(so), .so_en(so_en)
    );

    always #4 clk = ~clk;

    // R11 array pattern
    function automatic logic [7:0] pat(input int p, input int o);
        return 8'((o % 256 + 165 * (o / 256) + 71 * p) % 256);
    endfunction

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    // Per-clock comparison against the reference
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            n_cmp++;
            if (so_en !== exp_en || (exp_en && so !== exp_so)) begin
                n_bad++;
                $display("FAIL %s: so_en=%b so=%b expected so_en=%b so=%b at %0t",
                         cur_req, so_en, so, exp_en, exp_so, $time);
            end
        end
    end

    task automatic run_read(input logic [7:0] op, input int pg, input int of,
                            input bit p264, input bit idle_hi, input int nbits,
                            input string tag);
        bit   hq[$];
        logic [7:0] bq[$];
        int   p, o, last, nfill;
        bit   known, strm;
        logic [23:0] a;
        cur_req = tag;
        known = (op == 8'h03 || op == 8'h0B || op == 8'hE8 || op == 8'hD2);
        strm  = (op != 8'hD2);
        nfill = (op == 8'h0B) ? 1 : ((op == 8'hE8 || op == 8'hD2) ? 4 : 0);
        p = pg % NP;
        if (p264) begin
            o = (of >= 264) ? of - 264 : of;
            a = {3'b000, 12'(pg), 9'(of)};
            last = 263;
        end else begin
            o = of % 256;
            a = {4'b0000, 12'(pg), 8'(of)};
            last = 255;
        end
        for (int k = 0; k < (nbits + 7) / 8; k++) begin
            bq.push_back(pat(p, o));
            if (o == last) begin
                o = 0;
                if (strm) p = (p + 1) % NP;
            end else o++;
        end
        for (int i = 7; i >= 0; i--) hq.push_back(op[i]);
        for (int i = 23; i >= 0; i--) hq.push_back(a[i]);
        for (int i = 0; i < nfill * 8; i++) hq.push_back(i[0]);
        page264 = p264;
        sck = idle_hi;
        half();
        cs_n = 1'b0;
        half();
        foreach (hq[i]) begin
            sck = 1'b0; si = hq[i]; half();
            sck = 1'b1; half();
        end
        for (int j = 0; j < nbits; j++) begin
            sck = 1'b0;
            si = j[0];
            if (known) begin
                exp_en = 1'b1;
                exp_so = bq[j / 8][7 - (j % 8)];
            end
            half();
            sck = 1'b1; half();
        end
        cs_n = 1'b1;
        exp_en = 1'b0;
        half();
        sck = idle_hi;
        half();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (so_en !== 1'b0) begin
            n_bad++;
            $display("FAIL R12: so_en=%b expected 0", so_en);
        end
        mon_on = 1'b1;
        run_read(8'h03, 1, 260, 1'b1, 1'b0, 80, "R1/R4/R5/R6");
        run_read(8'h0B, 3, 250, 1'b0, 1'b1, 80, "R4/R5/R7");
        run_read(8'hE8, 3, 258, 1'b1, 1'b0, 80, "R4/R7");
        run_read(8'hE8, 0, 252, 1'b0, 1'b1, 48, "R6");
        run_read(8'hD2, 2, 259, 1'b1, 1'b1, 80, "R4/R8");
        run_read(8'hD2, 0, 253, 1'b0, 1'b0, 64, "R8");
        run_read(8'h03, 6, 300, 1'b1, 1'b0, 40, "R2/R3/R11");
        run_read(8'h0B, 5, 17, 1'b0, 1'b0, 24, "R2/R11");
        run_read(8'h84, 1, 4, 1'b0, 1'b0, 40, "R10");
        run_read(8'h0B, 2, 100, 1'b1, 1'b0, 13, "R9");
        run_read(8'h03, 0, 0, 1'b0, 1'b1, 24, "R9");
        mon_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule